// File: doc/BRIEF.md
# Descriptor Memory Reply Engine

This block answers the IN data stage of a control transfer from a small local descriptor memory, so the CPU does not have to feed each packet by hand. Software fills the memory through one data-window register. A single address pointer, loaded through two byte-wide registers, selects the location. Every accepted window access, whether it reads or writes, moves the pointer on by one.

To answer a request, software loads the pointer with the first byte of the reply, writes a 16-bit byte count, and sets an arm bit. Each IN token then produces one packet on a byte handshake. The packet holds the endpoint's maximum packet size in bytes, or the bytes that remain if there are fewer. When the count is used up, the engine disarms itself and reports completion. If an OUT token arrives first, the host has moved to the status stage early. The engine then abandons the reply and reports both an abort flag and completion. Two sticky status flags drive an interrupt output, which is gated by per-flag enables and two master enables.

Top module: `desc_reply_engine`

## Requirements
- R1: Register offsets on `cpu_addr` are: 0 window select, 1 pointer high bits (pointer bits 9:8 in data bits 1:0), 2 pointer low byte, 3 data window, 4 count high byte, 5 count low byte, 6 control (bit 0 = arm), 7 max packet size, 8 status (bit 0 = done, bit 1 = aborted), 9 interrupt enables (bit 0 done enable, bit 1 abort enable, bit 2 control-endpoint master, bit 3 endpoint-group master). Reads return the value one cycle after `cpu_re`, and unused offsets read 0. After reset every register reads 0.
- R2: With window select equal to 0x02 and the engine not armed, a write to offset 3 stores the byte at the pointer and advances the pointer by one.
- R3: Under the same conditions, a read of offset 3 returns the byte at the pointer and advances the pointer by one. A read that follows a write therefore returns the next location, not the byte just written.
- R4: With any window select other than 0x02, an access to offset 3 changes neither memory nor pointer, and a read returns 0x00.
- R5: The pointer wraps from 1023 to 0, both for window accesses and during a reply.
- R6: On an IN token while armed with a nonzero max size, the engine presents min(max size, remaining count) bytes from consecutive addresses starting at the pointer. `tx_last` is high on the final byte only, and each byte advances when `tx_ready` is high.
- R7: When the remaining count reaches zero, the reply ends. This also holds when the count is an exact multiple of the max size: no zero-length packet follows, and later IN tokens produce no bytes.
- R8: Sending the last byte clears the arm bit and sets status done (bit 0) in the same cycle.
- R9: An OUT token while armed, before all bytes are sent, clears the arm bit, sets status done and aborted, and drops any packet in progress.
- R10: Arming with a count of zero completes at once: done is set and the arm bit is cleared one cycle later, and no byte is sent.
- R11: `irq` is high when (done and done enable and group master) or (aborted and abort enable and control-endpoint master and group master).
- R12: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R13: While armed, window accesses are ignored. IN tokens are ignored when not armed, or when the max size is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe |
| cpu_addr | input | 4 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after `cpu_re` |
| in_token | input | 1 | One-cycle pulse: IN token for the control endpoint |
| out_token | input | 1 | One-cycle pulse: OUT token (status stage) |
| tx_ready | input | 1 | Packet sink accepts the presented byte |
| tx_valid | output | 1 | A packet byte is presented |
| tx_data | output | 8 | Presented byte |
| tx_last | output | 1 | Presented byte ends the packet |
| irq | output | 1 | Active-high interrupt |

## Verification
The hardest case to reach is an OUT token that lands in the middle of a packet, after some bytes have been taken but before the last one. The bench gets there by holding back `tx_ready` after a chosen number of accepted bytes and then pulsing `out_token`. It then checks that no further byte appears, and that both status flags and the cleared arm bit read back correctly. Random replies with counts that are exact multiples of, or just past, the max size exercise the short-packet and no-zero-length-packet endings. A reply that starts just below the top of memory crosses the pointer wrap.

// File: rtl/desc_reply_pkg.sv
package desc_reply_pkg;
   localparam int CNT_W = 16;
   localparam int REG_AW = 4;

   localparam logic [REG_AW-1:0] A_WSEL = 4'd0;
   localparam logic [REG_AW-1:0] A_PTRH = 4'd1;
   localparam logic [REG_AW-1:0] A_PTRL = 4'd2;
   localparam logic [REG_AW-1:0] A_DATA = 4'd3;
   localparam logic [REG_AW-1:0] A_CNTH = 4'd4;
   localparam logic [REG_AW-1:0] A_CNTL = 4'd5;
   localparam logic [REG_AW-1:0] A_CTRL = 4'd6;
   localparam logic [REG_AW-1:0] A_MAXP = 4'd7;
   localparam logic [REG_AW-1:0] A_STAT = 4'd8;
   localparam logic [REG_AW-1:0] A_IEN  = 4'd9;

   localparam logic [7:0] WSEL_DESC = 8'h02;

   localparam int ST_DONE  = 0;
   localparam int ST_ABORT = 1;
   localparam int IE_DONE  = 0;
   localparam int IE_ABORT = 1;
   localparam int IE_EP0   = 2;
   localparam int IE_GRP   = 3;

   typedef enum logic [0:0] {ENG_IDLE, ENG_SEND} eng_state_t;
endpackage

// File: rtl/desc_ram.sv
module desc_ram #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/desc_reply_regs.sv
module desc_reply_regs
   import desc_reply_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_we,
   input  logic              cpu_re,
   input  logic [REG_AW-1:0] cpu_addr,
   input  logic [7:0]        cpu_wdata,
   output logic [7:0]        cpu_rdata,
   output logic              ram_we,
   input  logic [7:0]        ram_rdata,
   output logic [ADDR_W-1:0] ptr,
   output logic [CNT_W-1:0]  remain,
   output logic [7:0]        maxpkt,
   output logic              armed,
   output logic              sts_done,
   output logic              sts_abort,
   input  logic              eng_step,
   input  logic              eng_done,
   input  logic              eng_abort,
   output logic              irq
);
   localparam int HI_W = ADDR_W - 8;

   logic [7:0] wsel;
   logic [3:0] ien;
   logic       win_ok, win_wr, win_rd;
   logic       clr_done, clr_abort;
   logic       irq_comb;
   logic [7:0] rd_mux;

   assign win_ok    = (wsel == WSEL_DESC) && !armed;
   assign win_wr    = cpu_we && (cpu_addr == A_DATA) && win_ok;
   assign win_rd    = cpu_re && (cpu_addr == A_DATA) && win_ok;
   assign ram_we    = win_wr;
   assign clr_done  = cpu_we && (cpu_addr == A_STAT) && cpu_wdata[ST_DONE];
   assign clr_abort = cpu_we && (cpu_addr == A_STAT) && cpu_wdata[ST_ABORT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wsel   <= '0;
         ptr    <= '0;
         remain <= '0;
         maxpkt <= '0;
         armed  <= 1'b0;
         ien    <= '0;
      end else begin
         if (cpu_we) begin
            case (cpu_addr)
               A_WSEL: wsel <= cpu_wdata;
               A_PTRH: ptr[ADDR_W-1:8] <= cpu_wdata[HI_W-1:0];
               A_PTRL: ptr[7:0] <= cpu_wdata;
               A_CNTH: remain[15:8] <= cpu_wdata;
               A_CNTL: remain[7:0] <= cpu_wdata;
               A_CTRL: armed <= cpu_wdata[0];
               A_MAXP: maxpkt <= cpu_wdata;
               A_IEN:  ien <= cpu_wdata[3:0];
               default: ;
            endcase
         end
         if (win_wr || win_rd || eng_step) ptr <= ptr + 1'b1;
         if (eng_step) remain <= remain - 1'b1;
         if (eng_done || eng_abort) armed <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_done  <= 1'b0;
         sts_abort <= 1'b0;
      end else begin
         sts_done  <= (sts_done & ~clr_done) | eng_done | eng_abort;
         sts_abort <= (sts_abort & ~clr_abort) | eng_abort;
      end
   end

   always_comb begin
      rd_mux = 8'h00;
      case (cpu_addr)
         A_WSEL: rd_mux = wsel;
         A_PTRH: rd_mux = 8'(ptr[ADDR_W-1:8]);
         A_PTRL: rd_mux = ptr[7:0];
         A_DATA: rd_mux = win_ok ? ram_rdata : 8'h00;
         A_CNTH: rd_mux = remain[15:8];
         A_CNTL: rd_mux = remain[7:0];
         A_CTRL: rd_mux = {7'd0, armed};
         A_MAXP: rd_mux = maxpkt;
         A_STAT: rd_mux = {6'd0, sts_abort, sts_done};
         A_IEN:  rd_mux = {4'd0, ien};
         default: rd_mux = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cpu_rdata <= 8'h00;
      else if (cpu_re) cpu_rdata <= rd_mux;
   end

   assign irq_comb = ien[IE_GRP] &
                     ((sts_done & ien[IE_DONE]) |
                      (sts_abort & ien[IE_ABORT] & ien[IE_EP0]));

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_comb;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_comb;
      end
   endgenerate

   // R2
   win_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr || win_rd) |=> ptr == $past(ptr) + 1'b1);
   // R4
   win_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cpu_we || cpu_re) && cpu_addr == A_DATA && wsel != WSEL_DESC && !armed)
      |=> $stable(ptr));
   // R12
   sts_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_abort |=> sts_done && sts_abort);
endmodule

// File: rtl/desc_reply_fsm.sv
module desc_reply_fsm
   import desc_reply_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             armed,
   input  logic [CNT_W-1:0] remain,
   input  logic [7:0]       maxpkt,
   input  logic             in_token,
   input  logic             out_token,
   input  logic             tx_ready,
   output logic             tx_valid,
   output logic             tx_last,
   output logic             eng_step,
   output logic             eng_done,
   output logic             eng_abort
);
   eng_state_t st;
   logic [7:0] chunk_left;
   logic       last_byte;
   logic       start_pkt;
   logic [7:0] chunk_len;

   assign tx_valid  = (st == ENG_SEND) && armed;
   assign tx_last   = tx_valid && (chunk_left == 8'd1);
   assign last_byte = tx_valid && tx_ready && (chunk_left == 8'd1) &&
                      (remain == CNT_W'(1));
   assign eng_done  = ((st == ENG_IDLE) && armed && (remain == '0)) || last_byte;
   assign eng_abort = armed && out_token && !eng_done;
   assign eng_step  = tx_valid && tx_ready && !eng_abort;
   assign start_pkt = (st == ENG_IDLE) && armed && !eng_done && !eng_abort &&
                      in_token && (maxpkt != 8'd0);
   assign chunk_len = (remain < CNT_W'(maxpkt)) ? remain[7:0] : maxpkt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ENG_IDLE;
         chunk_left <= '0;
      end else begin
         case (st)
            ENG_IDLE: begin
               if (start_pkt) begin
                  chunk_left <= chunk_len;
                  st         <= ENG_SEND;
               end
            end
            ENG_SEND: begin
               if (!armed || eng_abort) begin
                  st <= ENG_IDLE;
               end else if (eng_step) begin
                  chunk_left <= chunk_left - 8'd1;
                  if (chunk_left == 8'd1) st <= ENG_IDLE;
               end
            end
            default: st <= ENG_IDLE;
         endcase
      end
   end

   // R6
   chunk_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ENG_SEND) |-> chunk_left != 8'd0);
   // R7
   no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ENG_SEND && armed) |-> remain >= CNT_W'(chunk_left));
   // R13
   idle_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ENG_IDLE && (!armed || maxpkt == 8'd0)) |=> !tx_valid);
endmodule

// File: rtl/desc_reply_engine.sv
module desc_reply_engine
   import desc_reply_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cpu_we,
   input  logic       cpu_re,
   input  logic [3:0] cpu_addr,
   input  logic [7:0] cpu_wdata,
   output logic [7:0] cpu_rdata,
   input  logic       in_token,
   input  logic       out_token,
   input  logic       tx_ready,
   output logic       tx_valid,
   output logic [7:0] tx_data,
   output logic       tx_last,
   output logic       irq
);
   generate
      if (ADDR_W < 9 || ADDR_W > 12) begin : g_bad_aw
         $error("ADDR_W must lie in 9..12");
      end
   endgenerate

   logic              ram_we;
   logic [7:0]        ram_rdata;
   logic [ADDR_W-1:0] ptr;
   logic [CNT_W-1:0]  remain;
   logic [7:0]        maxpkt;
   logic              armed, sts_done, sts_abort;
   logic              eng_step, eng_done, eng_abort;

   desc_ram #(.ADDR_W(ADDR_W)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .addr  (ptr),
      .wdata (cpu_wdata),
      .rdata (ram_rdata)
   );

   desc_reply_regs #(.ADDR_W(ADDR_W), .IRQ_REG(IRQ_REG)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_we    (cpu_we),
      .cpu_re    (cpu_re),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_rdata (cpu_rdata),
      .ram_we    (ram_we),
      .ram_rdata (ram_rdata),
      .ptr       (ptr),
      .remain    (remain),
      .maxpkt    (maxpkt),
      .armed     (armed),
      .sts_done  (sts_done),
      .sts_abort (sts_abort),
      .eng_step  (eng_step),
      .eng_done  (eng_done),
      .eng_abort (eng_abort),
      .irq       (irq)
   );

   desc_reply_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed     (armed),
      .remain    (remain),
      .maxpkt    (maxpkt),
      .in_token  (in_token),
      .out_token (out_token),
      .tx_ready  (tx_ready),
      .tx_valid  (tx_valid),
      .tx_last   (tx_last),
      .eng_step  (eng_step),
      .eng_done  (eng_done),
      .eng_abort (eng_abort)
   );

   assign tx_data = ram_rdata;

   // R9
   early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && out_token && !(tx_valid && tx_ready && tx_last && remain == 16'd1))
      |=> !armed && sts_abort && sts_done);
   // R8
   final_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_last && remain == 16'd1) |=> !armed && sts_done);
   // R10
   zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && remain == 16'd0 && !tx_valid) |=> !armed && sts_done);
endmodule

// File: tb/desc_reply_engine_bench.sv
module desc_reply_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MEM_N = 1024;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_we = 1'b0, cpu_re = 1'b0;
   logic [3:0] cpu_addr = '0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic       in_token = 1'b0, out_token = 1'b0, tx_ready = 1'b0;
   logic       tx_valid, tx_last, irq;
   logic [7:0] tx_data;

   int checks = 0;
   int failures = 0;
   logic [7:0] mm [MEM_N];
   int mptr = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   desc_reply_engine u_desc_reply_engine (
      .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_re(cpu_re),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .in_token(in_token), .out_token(out_token), .tx_ready(tx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .irq(irq)
   );

   function automatic int min_len(int a, int b);
      return (a < b) ? a : b;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(int a, int d);
      cpu_we = 1'b1; cpu_addr = 4'(a); cpu_wdata = 8'(d);
      @(negedge clk);
      cpu_we = 1'b0;
   endtask

   task automatic rd(int a, output int d);
      cpu_re = 1'b1; cpu_addr = 4'(a);
      @(negedge clk);
      cpu_re = 1'b0;
      d = int'(cpu_rdata);
   endtask

   task automatic set_ptr(int a);
      wr(1, (a >> 8) & 3);
      wr(2, a & 255);
      mptr = a % MEM_N;
   endtask

   task automatic get_ptr(output int p);
      int h, l;
      rd(1, h); rd(2, l);
      p = (h << 8) | l;
   endtask

   task automatic win_wr(int d);
      wr(3, d);
      mm[mptr] = 8'(d);
      mptr = (mptr + 1) % MEM_N;
   endtask

   task automatic pulse_in();
      in_token = 1'b1;
      @(negedge clk);
      in_token = 1'b0;
   endtask

   task automatic arm(int start, int cnt, int mp);
      set_ptr(start);
      wr(4, cnt >> 8);
      wr(5, cnt & 255);
      wr(7, mp);
      wr(6, 1);
   endtask

   // Collect one packet; returns number of bytes accepted
   task automatic take_packet(int start, int exp_len, int stop_after, output int n);
      int guard = 0;
      bit got_last = 1'b0;
      n = 0;
      while (!got_last && guard < 300 && n < stop_after) begin
         bit rdy;
         rdy = ($urandom % 4) != 0;
         tx_ready = rdy;
         if (tx_valid && rdy) begin
            chk(tx_data == mm[(start + n) % MEM_N], "R6 data", tx_data, mm[(start + n) % MEM_N]);
            chk(tx_last == (n == exp_len - 1), "R6 last", tx_last, n == exp_len - 1);
            if (tx_last) got_last = 1'b1;
            n++;
         end
         @(negedge clk);
         guard++;
      end
      tx_ready = 1'b0;
   endtask

   task automatic run_reply(int start, int cnt, int mp);
      int rem, addr, n, v, p;
      arm(start, cnt, mp);
      rem = cnt; addr = start;
      if (cnt == 0) @(negedge clk);
      while (rem > 0) begin
         pulse_in();
         take_packet(addr, min_len(mp, rem), 1 << 20, n);
         chk(n == min_len(mp, rem), "R6 packet length", n, min_len(mp, rem));
         rem -= min_len(mp, rem);
         addr = (addr + min_len(mp, rem + min_len(mp, rem))) % MEM_N;
         addr = (start + (cnt - rem)) % MEM_N;
         @(negedge clk);
      end
      pulse_in();
      v = 0;
      for (int i = 0; i < 3; i++) begin
         if (tx_valid) v = 1;
         @(negedge clk);
      end
      chk(v == 0, "R7 no packet after end", v, 0);
      rd(6, v); chk(v == 0, "R8 arm cleared", v, 0);
      rd(8, v); chk(v == 1, "R8 done status", v, 1);
      get_ptr(p); chk(p == (start + cnt) % MEM_N, "R5 pointer after reply", p, (start + cnt) % MEM_N);
      wr(8, 3);
      rd(8, v); chk(v == 0, "R12 status cleared", v, 0);
   endtask

   initial begin
      int v, p, n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 16; a++) begin
         rd(a, v);
         if (a != 3) chk(v == 0, "R1 reset value", v, 0);
      end
      chk(tx_valid == 0, "R1 tx_valid reset", tx_valid, 0);
      chk(irq == 0, "R1 irq reset", irq, 0);

      // R1 readback
      wr(7, 8'h40); rd(7, v); chk(v == 8'h40, "R1 maxpkt", v, 8'h40);
      wr(9, 8'h0F); rd(9, v); chk(v == 8'h0F, "R1 ien", v, 8'h0F);
      wr(9, 0);
      wr(4, 8'h12); rd(4, v); chk(v == 8'h12, "R1 count hi", v, 8'h12);
      wr(5, 8'h34); rd(5, v); chk(v == 8'h34, "R1 count lo", v, 8'h34);
      wr(4, 0); wr(5, 0);

      // Fill memory through window (R2)
      wr(0, 2);
      set_ptr(0);
      for (int i = 0; i < MEM_N; i++) win_wr($urandom % 256);
      get_ptr(p); chk(p == 0, "R5 wrap after full fill", p, 0);

      // R2 / R3 directed
      set_ptr(16'h010);
      win_wr(8'hA1); win_wr(8'hB2); win_wr(8'hC3);
      get_ptr(p); chk(p == 16'h013, "R2 pointer advance", p, 16'h013);
      set_ptr(16'h010);
      rd(3, v); chk(v == 8'hA1, "R3 read first", v, 8'hA1);
      rd(3, v); chk(v == 8'hB2, "R3 read second", v, 8'hB2);
      set_ptr(16'h020);
      win_wr(8'h5A);
      rd(3, v); chk(v == mm[16'h021], "R3 read after write gives next", v, mm[16'h021]);

      // R4 window blocked
      wr(0, 1);
      set_ptr(16'h030);
      wr(3, 8'hEE);
      get_ptr(p); chk(p == 16'h030, "R4 pointer held on write", p, 16'h030);
      rd(3, v); chk(v == 0, "R4 read returns zero", v, 0);
      get_ptr(p); chk(p == 16'h030, "R4 pointer held on read", p, 16'h030);
      wr(0, 2);
      rd(3, v); chk(v == mm[16'h030], "R4 memory untouched", v, mm[16'h030]);

      // R5 wrap on window write
      set_ptr(16'h3FF);
      win_wr(8'h77);
      get_ptr(p); chk(p == 0, "R5 window wrap", p, 0);

      // R10 zero count
      run_reply(16'h100, 0, 8);

      // Directed replies: exact multiple, short, across wrap (R5, R6, R7)
      run_reply(16'h040, 16, 8);
      run_reply(16'h050, 3, 8);
      run_reply(16'h3FE, 6, 4);
      run_reply(16'h060, 17, 16);

      // Random replies
      for (int it = 0; it < 25; it++) begin
         int mp, cnt, st;
         mp  = 1 + ($urandom % 16);
         cnt = (it % 3 == 0) ? mp * (1 + $urandom % 3) : ($urandom % 40);
         st  = $urandom % MEM_N;
         run_reply(st, cnt, mp);
      end

      // R9 early OUT mid packet
      arm(16'h080, 20, 8);
      pulse_in();
      take_packet(16'h080, 8, 3, n);
      chk(n == 3, "R9 partial bytes", n, 3);
      out_token = 1'b1;
      @(negedge clk);
      out_token = 1'b0;
      chk(tx_valid == 0, "R9 packet dropped", tx_valid, 0);
      rd(6, v); chk(v == 0, "R9 arm cleared", v, 0);
      rd(8, v); chk(v == 3, "R9 status both", v, 3);

      // R11 interrupt gating
      wr(9, 8'h0A); chk(irq == 0, "R11 abort path needs ep0 master", irq, 0);
      wr(9, 8'h0E); chk(irq == 1, "R11 abort path", irq, 1);
      wr(9, 8'h07); chk(irq == 0, "R11 group master off", irq, 0);
      wr(8, 2);
      rd(8, v); chk(v == 1, "R12 clear abort only", v, 1);
      wr(9, 8'h0E); chk(irq == 0, "R11 abort cleared", irq, 0);
      wr(9, 8'h09); chk(irq == 1, "R11 done path", irq, 1);
      wr(8, 0);
      rd(8, v); chk(v == 1, "R12 write zero keeps", v, 1);
      wr(8, 1); chk(irq == 0, "R11 irq drops after clear", irq, 0);
      wr(9, 0);

      // R13 ignored while armed / max size zero / unarmed
      arm(16'h090, 5, 0);
      pulse_in();
      v = 0;
      for (int i = 0; i < 3; i++) begin if (tx_valid) v = 1; @(negedge clk); end
      chk(v == 0, "R13 max size zero gives no bytes", v, 0);
      wr(3, 8'h11);
      get_ptr(p); chk(p == 16'h090, "R13 window ignored while armed", p, 16'h090);
      rd(6, v); chk(v == 1, "R13 still armed", v, 1);
      wr(6, 0);
      pulse_in();
      v = 0;
      for (int i = 0; i < 3; i++) begin if (tx_valid) v = 1; @(negedge clk); end
      chk(v == 0, "R13 unarmed IN ignored", v, 0);
      rd(3, v); chk(v == mm[16'h090], "R13 memory untouched", v, mm[16'h090]);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule